// File: doc/BRIEF.md
# Serial ADC Master with Independent Clock Phases

This block is a mode-0 SPI master for a serial analog-to-digital converter. One request runs a 16-clock frame. The transmit word goes out on the serial data line, most significant bit first. The converter's reply is shifted in, also most significant bit first, and is handed back as a 16-bit word.

The serial clock is built from two separately programmed phase lengths, both counted in system-clock cycles. The low phase can therefore be stretched to cover a slow converter output delay, while the high phase stays at its minimum, which keeps the frame rate high. Chip-select setup time before the first clock, and chip-select quiet time after the frame, are also programmable.

The block is used through a start/busy/done handshake. Its phase settings are captured when a frame starts.

Top module: `adc_spi_master`

## Requirements
- R1: After reset and whenever idle, `csN` is 1, `sclk` is 0, `busy` is 0 and `done` is 0; `sdi` is 0 after reset.
- R2: A frame has exactly 16 rising `sclk` edges while `csN` is 0. `sdi` carries `txWord` bit 15 first, down to bit 0, and is stable across every rising edge. The word is taken from `txWord` in the cycle `start` is accepted.
- R3: `sdo` is sampled on the last system-clock cycle of each low phase, and the first sample becomes bit 15 of `rxWord`. `rxWord` is updated only in the cycle `done` is 1, and it holds its value until the next `done`.
- R4: Each high phase lasts `highCnt` cycles and each low phase inside the frame lasts `lowCnt` cycles. A setting of 0 acts as 1.
- R5: `csN` goes to 0 and `sclk` stays 0 for `csSetupCnt` cycles (0 acts as 1) before the first low phase. The first low run is therefore `csSetupCnt + lowCnt` cycles long.
- R6: After the 16th high phase, `sclk` is 0 for exactly one cycle with `csN` still 0, and then `csN` rises.
- R7: `csN` stays 1 with `busy` held at 1 for `csQuietCnt` cycles (0 acts as 1). Then `done` pulses for one cycle, and `busy` is 0 in that same cycle.
- R8: A `start` seen while `busy` is 1 is ignored. No extra frame follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Frame request, accepted while idle |
| txWord | input | 16 | Word to send |
| highCnt | input | 8 | Serial clock high-phase length in cycles |
| lowCnt | input | 8 | Serial clock low-phase length in cycles |
| csSetupCnt | input | 8 | Cycles from chip select low to the first low phase |
| csQuietCnt | input | 8 | Cycles chip select stays high before done |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rxWord | output | 16 | Last received word |
| csN | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, idles low |
| sdi | output | 1 | Serial data to the converter |
| sdo | input | 1 | Serial data from the converter |

## Verification
A wrong phase counter shows up within one serial clock period as a high or low run of the wrong length on `sclk`. A wrong bit counter changes the number of rising edges and moves the point where `csN` rises within the same frame. A capture taken at the wrong point, or a shift in the wrong direction, corrupts `rxWord` at the next `done`. The bench models a converter whose output lags each falling edge by a programmable delay. Received words must match under both symmetric and skewed clock settings. With a low phase shorter than that delay, the bench expects the predicted one-bit-late word.

// File: rtl/adc_spi_pkg.sv
package adc_spi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_LOW, ST_HIGH, ST_TAIL, ST_QUIET
  } spiState_t;

  typedef struct packed {
    logic loadTx;
    logic shiftTx;
    logic sampleRx;
    logic latchRx;
  } spiStrobe_t;
endpackage

// File: rtl/adc_spi_ctrl.sv
module adc_spi_ctrl
  import adc_spi_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] highCnt,
  input  logic [CNT_W-1:0] lowCnt,
  input  logic [CNT_W-1:0] csSetupCnt,
  input  logic [CNT_W-1:0] csQuietCnt,
  output spiStrobe_t       strb,
  output logic             csN,
  output logic             sclk,
  output logic             busy,
  output logic             done
);
  localparam int BIT_W = $clog2(FRAME_BITS);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  spiState_t        state;
  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bitCnt;
  logic [CNT_W-1:0] hiCfg, loCfg, quCfg;
  logic             csNQ, sclkQ, doneQ;
  logic             lastCycle, lastBit;

  function automatic logic [CNT_W-1:0] atLeastOne(input logic [CNT_W-1:0] v);
    return (v == '0) ? ONE : v;
  endfunction

  assign lastCycle = (cnt == ONE);
  assign lastBit   = (bitCnt == LAST_BIT);

  always_comb begin
    strb.loadTx   = (state == ST_IDLE) && start;
    strb.shiftTx  = (state == ST_HIGH) && lastCycle && !lastBit;
    strb.sampleRx = (state == ST_LOW) && lastCycle;
    strb.latchRx  = (state == ST_QUIET) && lastCycle;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitCnt <= '0;
      hiCfg  <= ONE;
      loCfg  <= ONE;
      quCfg  <= ONE;
      csNQ   <= 1'b1;
      sclkQ  <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            hiCfg <= atLeastOne(highCnt);
            loCfg <= atLeastOne(lowCnt);
            quCfg <= atLeastOne(csQuietCnt);
            cnt   <= atLeastOne(csSetupCnt);
            csNQ  <= 1'b0;
            state <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (lastCycle) begin
            cnt   <= loCfg;
            state <= ST_LOW;
          end else begin
            cnt <= cnt - ONE;
          end
        end
        ST_LOW: begin
          if (lastCycle) begin
            cnt   <= hiCfg;
            sclkQ <= 1'b1;
            state <= ST_HIGH;
          end else begin
            cnt <= cnt - ONE;
          end
        end
        ST_HIGH: begin
          if (lastCycle) begin
            sclkQ <= 1'b0;
            if (lastBit) begin
              bitCnt <= '0;
              state  <= ST_TAIL;
            end else begin
              bitCnt <= bitCnt + 1'b1;
              cnt    <= loCfg;
              state  <= ST_LOW;
            end
          end else begin
            cnt <= cnt - ONE;
          end
        end
        ST_TAIL: begin
          csNQ  <= 1'b1;
          cnt   <= quCfg;
          state <= ST_QUIET;
        end
        ST_QUIET: begin
          if (lastCycle) begin
            doneQ <= 1'b1;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt - ONE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign csN  = csNQ;
  assign sclk = sclkQ;
  assign busy = (state != ST_IDLE);
  assign done = doneQ;

  // R1: idle state keeps the serial lines parked
  a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> (csNQ && !sclkQ));

  // R3: capture only while the clock is low inside a frame
  a_r3_sample_in_low: assert property (@(posedge clk) disable iff (!rstN)
    strb.sampleRx |-> (!sclkQ && !csNQ));

  // R5: setup window has chip select asserted and no clock
  a_r5_setup_quiet_clock: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SETUP) |-> (!csNQ && !sclkQ));

  // R6: chip select never rises straight out of a high phase
  a_r6_cs_after_low: assert property (@(posedge clk) disable iff (!rstN)
    sclkQ |=> !csNQ);

  // R7: done is a single-cycle pulse
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

  // R4: phase counters never run at zero while timing a phase
  a_r4_cnt_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    (state inside {ST_SETUP, ST_LOW, ST_HIGH, ST_QUIET}) |-> (cnt != '0));
endmodule

// File: rtl/adc_spi_datapath.sv
module adc_spi_datapath
  import adc_spi_pkg::*;
#(
  parameter int FRAME_BITS = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  spiStrobe_t            strb,
  input  logic [FRAME_BITS-1:0] txWord,
  input  logic                  sdo,
  output logic                  sdi,
  output logic [FRAME_BITS-1:0] rxWord
);
  logic [FRAME_BITS-1:0] txShift, rxShift, rxHold;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      rxHold  <= '0;
    end else begin
      if (strb.loadTx)
        txShift <= txWord;
      else if (strb.shiftTx)
        txShift <= {txShift[FRAME_BITS-2:0], 1'b0};
      if (strb.sampleRx)
        rxShift <= {rxShift[FRAME_BITS-2:0], sdo};
      if (strb.latchRx)
        rxHold <= rxShift;
    end
  end

  assign sdi    = txShift[FRAME_BITS-1];
  assign rxWord = rxHold;

  // R2: first bit on the line is the top bit of the accepted word
  a_r2_first_bit: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadTx |=> (sdi == $past(txWord[FRAME_BITS-1])));

  // R3: received word moves only on the latch strobe
  a_r3_rx_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latchRx |=> $stable(rxWord));
endmodule

// File: rtl/adc_spi_master.sv
module adc_spi_master
  import adc_spi_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int CNT_W      = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [FRAME_BITS-1:0] txWord,
  input  logic [CNT_W-1:0]      highCnt,
  input  logic [CNT_W-1:0]      lowCnt,
  input  logic [CNT_W-1:0]      csSetupCnt,
  input  logic [CNT_W-1:0]      csQuietCnt,
  output logic                  busy,
  output logic                  done,
  output logic [FRAME_BITS-1:0] rxWord,
  output logic                  csN,
  output logic                  sclk,
  output logic                  sdi,
  input  logic                  sdo
);
  spiStrobe_t strb;

  adc_spi_ctrl #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .highCnt(highCnt), .lowCnt(lowCnt),
    .csSetupCnt(csSetupCnt), .csQuietCnt(csQuietCnt),
    .strb(strb), .csN(csN), .sclk(sclk), .busy(busy), .done(done)
  );

  adc_spi_datapath #(.FRAME_BITS(FRAME_BITS)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .txWord(txWord),
    .sdo(sdo), .sdi(sdi), .rxWord(rxWord)
  );

  // R2: data line is steady across every rising clock edge
  a_r2_sdi_stable_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclk) |-> $stable(sdi));
endmodule

// File: tb/adc_spi_master_bench.sv
`timescale 1ns/1ps
module adc_spi_master_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] txWord = '0;
  logic [7:0]  highCnt = 8'd1, lowCnt = 8'd1, csSetupCnt = 8'd1, csQuietCnt = 8'd1;
  logic        busy, done, csN, sclk, sdi;
  logic [15:0] rxWord;
  logic        sdoM = 1'b0;

  always #2 clk = ~clk;

  adc_spi_master u_adc_spi_master (
    .clk(clk), .rstN(rstN), .start(start), .txWord(txWord),
    .highCnt(highCnt), .lowCnt(lowCnt), .csSetupCnt(csSetupCnt), .csQuietCnt(csQuietCnt),
    .busy(busy), .done(done), .rxWord(rxWord), .csN(csN), .sclk(sclk),
    .sdi(sdi), .sdo(sdoM)
  );

  typedef struct {
    logic [15:0] rx;
    logic [15:0] tx;
    int hi, lo, su, qu;
  } item_t;
  item_t expQ[$];

  int errors = 0, checks = 0, cyc = 0, frames = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // converter model: output delay after chip select fall and each falling clock
  logic [15:0] slaveWord = '0;
  logic [15:0] slaveRx = '0;
  int outDly = 27;
  int sIdx = 16;
  always @(negedge csN or negedge sclk or posedge csN) begin
    if (csN) sIdx = 16;
    else if (sIdx == 16) begin
      sIdx = 15;
      sdoM <= #(outDly) slaveWord[15];
    end else begin
      sIdx = sIdx - 1;
      if (sIdx >= 0) sdoM <= #(outDly) slaveWord[sIdx];
    end
  end
  always @(posedge sclk) if (!csN) slaveRx = {slaveRx[14:0], sdi};

  // monitor / scoreboard
  int hiRun = 0, loRun = 0, numHigh = 0, firstLow = 0, endLow = 0;
  int quietRun = 0, hiBad = 0, loBad = 0;
  bit seenHigh = 0;
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (!csN) begin
        if (sclk) begin
          if (loRun > 0) begin
            if (!seenHigh) firstLow = loRun;
            else if (expQ.size() > 0 && loRun != expQ[0].lo) loBad++;
            loRun = 0;
          end
          seenHigh = 1;
          hiRun++;
        end else begin
          if (hiRun > 0) begin
            numHigh++;
            if (expQ.size() > 0 && hiRun != expQ[0].hi) hiBad++;
            hiRun = 0;
          end
          loRun++;
        end
      end else begin
        if (loRun > 0) begin endLow = loRun; loRun = 0; end
        if (busy) quietRun++;
      end
      if (done) begin
        if (expQ.size() == 0) begin
          check(0, "R8", "unexpected frame", 1, 0);
        end else begin
          item_t it;
          it = expQ.pop_front();
          check(rxWord == it.rx, "R3", "rxWord", int'(rxWord), int'(it.rx));
          check(slaveRx == it.tx, "R2", "sdi word at converter", int'(slaveRx), int'(it.tx));
          check(numHigh == 16, "R2", "rising edges", numHigh, 16);
          check(hiBad == 0, "R4", "bad high phases", hiBad, 0);
          check(loBad == 0, "R4", "bad low phases", loBad, 0);
          check(firstLow == it.su + it.lo, "R5", "first low run", firstLow, it.su + it.lo);
          check(endLow == 1, "R6", "tail low run", endLow, 1);
          check(quietRun == it.qu, "R7", "quiet cycles", quietRun, it.qu);
          check(!busy, "R7", "busy at done", int'(busy), 0);
        end
        frames++;
        hiRun = 0; loRun = 0; numHigh = 0; firstLow = 0; endLow = 0;
        quietRun = 0; hiBad = 0; loBad = 0; seenHigh = 0;
      end
    end
  end

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic pushAndStart(input logic [15:0] tx, input logic [15:0] sw,
                              input logic [15:0] rxExp, input int hi, input int lo,
                              input int su, input int qu, input int dly);
    item_t it;
    it.rx = rxExp; it.tx = tx;
    it.hi = eff(hi); it.lo = eff(lo); it.su = eff(su); it.qu = eff(qu);
    expQ.push_back(it);
    highCnt = 8'(hi); lowCnt = 8'(lo); csSetupCnt = 8'(su); csQuietCnt = 8'(qu);
    slaveWord = sw; outDly = dly;
    @(negedge clk);
    start = 1'b1; txWord = tx;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic runFrame(input logic [15:0] tx, input logic [15:0] sw,
                          input logic [15:0] rxExp, input int hi, input int lo,
                          input int su, input int qu, input int dly);
    pushAndStart(tx, sw, rxExp, hi, lo, su, qu, dly);
    waitDone();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(csN == 1'b1 && sclk == 1'b0, "R1", "lines in reset", {csN, sclk}, 2'b10);
    check(!busy && !done && !sdi, "R1", "busy/done/sdi in reset", {busy, done, sdi}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(csN == 1'b1 && sclk == 1'b0 && !busy, "R1", "idle lines", {csN, sclk, busy}, 3'b100);

    // R3 symmetric clock, long enough for the output delay
    runFrame(16'hA5C3, 16'h3C5A, 16'h3C5A, 8, 8, 2, 3, 27);
    // R4 skewed clock: stretched low, short high
    runFrame(16'h0F0F, 16'hBEEF, 16'hBEEF, 5, 8, 2, 2, 27);
    // R4 skewed with the longer delay
    runFrame(16'hFFFF, 16'h8001, 16'h8001, 5, 9, 3, 4, 35);
    runFrame(16'h0000, 16'h7FFE, 16'h7FFE, 6, 9, 1, 1, 35);
    // R3 low phase shorter than the delay: each bit after the first lands one late
    runFrame(16'h1234, 16'hC6A9, {1'b1, 15'(16'hC6A9 >> 1)}, 5, 5, 2, 2, 27);
    // R4 R5 R7 zero settings act as one
    runFrame(16'h8421, 16'h5AA5, 16'h5AA5, 0, 7, 0, 0, 27);

    // R3 received word holds after done
    held = rxWord;
    repeat (20) @(negedge clk);
    check(rxWord == held, "R3", "rxWord hold", int'(rxWord), int'(held));

    // R8 start during a frame is ignored; txWord change mid-frame has no effect (R2)
    pushAndStart(16'hC0DE, 16'h1357, 16'h1357, 4, 8, 2, 2, 27);
    repeat (30) @(negedge clk);
    start = 1'b1; txWord = 16'h5555;
    @(negedge clk);
    start = 1'b0;
    waitDone();
    begin
      bit stayedIdle = 1;
      for (int i = 0; i < 40; i++) begin
        if (!csN || busy) stayedIdle = 0;
        @(negedge clk);
      end
      check(stayedIdle, "R8", "no frame after ignored start", int'(stayedIdle), 1);
    end
    check(frames == 7, "R8", "frame count", frames, 7);
    check(expQ.size() == 0, "R8", "scoreboard empty", expQ.size(), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule